// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This controller turns the PLL of a shared frequency synthesizer on and off when asked. An enable request starts a bring-up sequence. The sequencer writes one control per clock, in a fixed order: it releases the PLL soft reset, programs the reference-bandwidth select to the good-reference code, loads the feedback divider and removes the power-down. It then waits a bounded time for the lock indication. A disable request starts the tear-down sequence. This removes power first and only then re-applies the soft reset.

The block reports `busy` for as long as a sequence runs. When the sequence ends, it raises a one-cycle `done` or a one-cycle `err`. `enabled` reflects the power control as seen through its polarity. The lock budget is given as a clock frequency and a time in microseconds, and the block turns these into a cycle count. Parameters remove the reset-control step or the lock wait, for PLLs that lack those controls.

States: `ST_IDLE`, `ST_REL_RST`, `ST_SET_BW`, `ST_LOAD_DIV`, `ST_PWR_UP`, `ST_WAIT_LOCK`, `ST_PWR_DN`, `ST_HOLD_RST`. The transitions are as follows.
- From IDLE, a disable request goes to PWR_DN. An enable request goes to REL_RST, or to SET_BW when there is no reset control.
- REL_RST goes to SET_BW, SET_BW goes to LOAD_DIV, and LOAD_DIV goes to PWR_UP.
- PWR_UP goes to WAIT_LOCK, or back to IDLE when there is no lock status.
- WAIT_LOCK returns to IDLE on lock (done) or on timeout (error).
- PWR_DN goes to HOLD_RST, or to IDLE when there is no reset control.
- HOLD_RST returns to IDLE (done).

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `pll_rst_n`=0, `pll_pwrdn`=PWRDN_ACTIVE, `pll_bw`=3, `pll_div`=0, and `busy`, `done`, `err` and `enabled` are all 0.
- R2: An enable request sampled at clock edge E0 produces one control change per edge. `pll_rst_n` rises at E1, `pll_bw` is written at E2, `pll_div` at E3 and power-up at E4. The PLL is never powered up while it is still held in reset or while the bandwidth select is not the good-reference code.
- R3: The bandwidth codes are: 0 for a good reference, 1 for a very bad one, 2 for a bad one and 3 for a very good one. Bring-up always writes code 0.
- R4: `pll_div` loads the `div_cfg` value captured at the edge that accepted the request. `fb_mult` always equals `pll_div` + 16.
- R5: In the cycles of WAIT_LOCK, a lock seen high at any of the first TIMEOUT cycles ends the sequence, the last of those cycles included. `done` is then high for exactly one cycle, the cycle after that edge. `done` and `err` are never high together.
- R6: If lock stays low for TIMEOUT wait cycles, `err` pulses for one cycle and the PLL is left powered, so `enabled` stays 1.
- R7: A disable request sampled at E0 sets `pll_pwrdn` to PWRDN_ACTIVE at E1 and drives `pll_rst_n` to 0 at E2. `done` is high in the cycle after E2.
- R8: `enabled` is 1 exactly when `pll_pwrdn` differs from PWRDN_ACTIVE. Both polarities are supported.
- R9: Requests that arrive while `busy` is high are ignored; they change no control output. `busy` falls on the same edge at which `done` or `err` rises.
- R10: An enable and a disable request in the same cycle are treated as a disable.
- R11: With HAS_LOCK_STAT=0, `done` rises on the same edge that applies power.
- R12: With HAS_RESET_CTL=0, `pll_rst_n` is held at 1. Bring-up starts with the bandwidth write, and tear-down finishes with `done` right after power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Request to bring the PLL up |
| dis_req | input | 1 | Request to take the PLL down |
| div_cfg | input | DIV_W | Feedback divider value to load |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_rst_n | output | 1 | Soft reset to the PLL, low means reset |
| pll_bw | output | 2 | Reference-bandwidth select |
| pll_div | output | DIV_W | Feedback divider control |
| pll_pwrdn | output | 1 | Power-down control, active at PWRDN_ACTIVE |
| fb_mult | output | MULT_W | Feedback multiplier implied by `pll_div` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends normally |
| err | output | 1 | One-cycle pulse when the lock wait times out |
| enabled | output | 1 | PLL is powered, read through the polarity |

## Verification
The assertions assume that `pll_lock` is synchronous to `clk` and stable around the sampling edge. They also assume that requests are sampled only at clock edges, and that reset is held low before the first edge. The bench drives every request, `div_cfg` and its lock model on the falling edge. The modelled lock therefore rises a set number of cycles after power is applied and is never seen changing at an active edge. The bench also sweeps the lock delay across the exact timeout boundary.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REL_RST,
        ST_SET_BW,
        ST_LOAD_DIV,
        ST_PWR_UP,
        ST_WAIT_LOCK,
        ST_PWR_DN,
        ST_HOLD_RST
    } seq_state_e;

    // reference-bandwidth select codes
    localparam logic [1:0] BW_GOOD  = 2'd0;
    localparam logic [1:0] BW_VBAD  = 2'd1;
    localparam logic [1:0] BW_BAD   = 2'd2;
    localparam logic [1:0] BW_VGOOD = 2'd3;

    // one strobe per control write
    typedef struct packed {
        logic rel_rst;
        logic set_bw;
        logic load_div;
        logic pwr_up;
        logic pwr_dn;
        logic hold_rst;
    } seq_act_t;

endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int TIMEOUT_CYC = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter bit HAS_RESET_CTL = 1'b1,
    parameter bit HAS_LOCK_STAT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_req,
    input  logic     dis_req,
    input  logic     pll_lock,
    input  logic     tmo,
    output seq_act_t act,
    output logic     waiting,
    output logic     accept_en,
    output logic     busy,
    output logic     done,
    output logic     err
);
    seq_state_e state, nxt;
    logic       fin_ok, fin_bad;

    always_comb begin
        nxt     = state;
        fin_ok  = 1'b0;
        fin_bad = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (dis_req)
                    nxt = ST_PWR_DN;
                else if (en_req)
                    nxt = HAS_RESET_CTL ? ST_REL_RST : ST_SET_BW;
            end
            ST_REL_RST:  nxt = ST_SET_BW;
            ST_SET_BW:   nxt = ST_LOAD_DIV;
            ST_LOAD_DIV: nxt = ST_PWR_UP;
            ST_PWR_UP: begin
                if (HAS_LOCK_STAT) begin
                    nxt = ST_WAIT_LOCK;
                end else begin
                    nxt    = ST_IDLE;
                    fin_ok = 1'b1;
                end
            end
            ST_WAIT_LOCK: begin
                if (pll_lock) begin
                    nxt    = ST_IDLE;
                    fin_ok = 1'b1;
                end else if (tmo) begin
                    nxt     = ST_IDLE;
                    fin_bad = 1'b1;
                end
            end
            ST_PWR_DN: begin
                if (HAS_RESET_CTL) begin
                    nxt = ST_HOLD_RST;
                end else begin
                    nxt    = ST_IDLE;
                    fin_ok = 1'b1;
                end
            end
            ST_HOLD_RST: begin
                nxt    = ST_IDLE;
                fin_ok = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= fin_ok;
            err   <= fin_bad;
        end
    end

    // outputs decoded from the state
    always_comb begin
        act          = '0;
        act.rel_rst  = (state == ST_REL_RST);
        act.set_bw   = (state == ST_SET_BW);
        act.load_div = (state == ST_LOAD_DIV);
        act.pwr_up   = (state == ST_PWR_UP);
        act.pwr_dn   = (state == ST_PWR_DN);
        act.hold_rst = (state == ST_HOLD_RST);
        waiting      = (state == ST_WAIT_LOCK);
        busy         = (state != ST_IDLE);
        accept_en    = (state == ST_IDLE) && en_req && !dis_req;
    end

    // R9
    idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE && $past(state) != ST_PWR_UP
         && $past(state) != ST_LOAD_DIV) |-> (state != ST_PWR_UP));

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_seq_pkg::*;
#(
    parameter int DIV_W         = 3,
    parameter bit HAS_RESET_CTL = 1'b1,
    parameter bit PWRDN_ACTIVE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_act_t         act,
    input  logic             cap_div,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             pll_rst_n,
    output logic [1:0]       pll_bw,
    output logic [DIV_W-1:0] pll_div,
    output logic             pll_pwrdn
);
    logic [DIV_W-1:0] div_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_hold  <= '0;
            pll_bw    <= BW_VGOOD;
            pll_div   <= '0;
            pll_pwrdn <= PWRDN_ACTIVE;
        end else begin
            if (cap_div)      div_hold  <= div_cfg;
            if (act.set_bw)   pll_bw    <= BW_GOOD;
            if (act.load_div) pll_div   <= div_hold;
            if (act.pwr_up)   pll_pwrdn <= ~PWRDN_ACTIVE;
            if (act.pwr_dn)   pll_pwrdn <= PWRDN_ACTIVE;
        end
    end

    generate
        if (HAS_RESET_CTL) begin : g_rst_ctl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pll_rst_n <= 1'b0;
                else if (act.rel_rst)
                    pll_rst_n <= 1'b1;
                else if (act.hold_rst)
                    pll_rst_n <= 1'b0;
            end
        end else begin : g_no_rst_ctl
            assign pll_rst_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int DIV_W          = 3,
    parameter int MULT_OFS       = 16,
    parameter int CLK_FREQ_HZ    = 250000000,
    parameter int LOCK_BUDGET_US = 10000,
    parameter bit HAS_RESET_CTL  = 1'b1,
    parameter bit HAS_LOCK_STAT  = 1'b1,
    parameter bit PWRDN_ACTIVE   = 1'b1,
    localparam int MULT_W = $clog2((1 << DIV_W) + MULT_OFS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              pll_lock,
    output logic              pll_rst_n,
    output logic [1:0]        pll_bw,
    output logic [DIV_W-1:0]  pll_div,
    output logic              pll_pwrdn,
    output logic [MULT_W-1:0] fb_mult,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              enabled
);
    localparam int TIMEOUT_CYC = (CLK_FREQ_HZ / 1000000) * LOCK_BUDGET_US;

    seq_act_t act;
    logic     waiting, tmo, accept_en;

    pll_seq_fsm #(
        .HAS_RESET_CTL (HAS_RESET_CTL),
        .HAS_LOCK_STAT (HAS_LOCK_STAT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .pll_lock  (pll_lock),
        .tmo       (tmo),
        .act       (act),
        .waiting   (waiting),
        .accept_en (accept_en),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    pll_lock_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (tmo)
    );

    pll_ctl_regs #(
        .DIV_W         (DIV_W),
        .HAS_RESET_CTL (HAS_RESET_CTL),
        .PWRDN_ACTIVE  (PWRDN_ACTIVE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .cap_div   (accept_en),
        .div_cfg   (div_cfg),
        .pll_rst_n (pll_rst_n),
        .pll_bw    (pll_bw),
        .pll_div   (pll_div),
        .pll_pwrdn (pll_pwrdn)
    );

    assign fb_mult = MULT_W'(pll_div) + MULT_W'(MULT_OFS);
    assign enabled = (pll_pwrdn != PWRDN_ACTIVE);

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done ^ err));

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R7
    teardown_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_n) |-> (pll_pwrdn == PWRDN_ACTIVE));

    // R2
    bringup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pll_pwrdn != PWRDN_ACTIVE) && ($past(pll_pwrdn) == PWRDN_ACTIVE))
        |-> (pll_rst_n && pll_bw == BW_GOOD));

    // R6
    err_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(pll_lock));

endmodule

// File: tb/pll_seq_ctrl_test.sv
`timescale 1ns/1ps
module pll_seq_ctrl_test;

    localparam int T = 20;   // 2 MHz nominal x 10 us budget

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;    // 250 MHz

    logic       en_req = 0, dis_req = 0, pll_lock = 0;
    logic [2:0] div_cfg = 0;
    logic       o_rst_n, o_pwrdn, o_busy, o_done, o_err, o_en;
    logic [1:0] o_bw;
    logic [2:0] o_div;
    logic [4:0] o_mult;

    pll_seq_ctrl #(.CLK_FREQ_HZ(2000000), .LOCK_BUDGET_US(10)) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .div_cfg(div_cfg), .pll_lock(pll_lock), .pll_rst_n(o_rst_n),
        .pll_bw(o_bw), .pll_div(o_div), .pll_pwrdn(o_pwrdn),
        .fb_mult(o_mult), .busy(o_busy), .done(o_done), .err(o_err),
        .enabled(o_en));

    // second build: no reset control, no lock status, power active low
    logic       en2 = 0, dis2 = 0;
    logic       b_rst_n, b_pwrdn, b_busy, b_done, b_err, b_en;
    logic [1:0] b_bw;
    logic [2:0] b_div;
    logic [4:0] b_mult;

    pll_seq_ctrl #(.CLK_FREQ_HZ(2000000), .LOCK_BUDGET_US(10),
                   .HAS_RESET_CTL(1'b0), .HAS_LOCK_STAT(1'b0),
                   .PWRDN_ACTIVE(1'b0)) uut2 (
        .clk(clk), .rst_n(rst_n), .en_req(en2), .dis_req(dis2),
        .div_cfg(3'd6), .pll_lock(1'b0), .pll_rst_n(b_rst_n),
        .pll_bw(b_bw), .pll_div(b_div), .pll_pwrdn(b_pwrdn),
        .fb_mult(b_mult), .busy(b_busy), .done(b_done), .err(b_err),
        .enabled(b_en));

    int checks = 0, errors = 0;
    bit cmp_on = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // PLL plant: lock rises lock_dly negedges after power with reset released
    int lock_dly = 3;
    int lk_cnt = 0;
    always @(negedge clk) begin
        if (o_pwrdn == 1'b0 && o_rst_n == 1'b1) begin
            lk_cnt = lk_cnt + 1;
            pll_lock = (lk_cnt >= lock_dly);
        end else begin
            lk_cnt = 0;
            pll_lock = 0;
        end
    end

    // behavioural reference: phase 0 idle, 1..4 bring-up steps, 5 wait, 10/11 tear-down
    int m_phase, m_wait, m_rst_n, m_bw, m_div, m_pwrdn, m_done, m_err, m_lat;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_wait = 0; m_rst_n = 0; m_bw = 3; m_div = 0;
            m_pwrdn = 1; m_done = 0; m_err = 0; m_lat = 0;
        end else begin
            m_done = 0; m_err = 0;
            case (m_phase)
                0: if (dis_req) m_phase = 10;
                   else if (en_req) begin m_lat = int'(div_cfg); m_phase = 1; end
                1: begin m_rst_n = 1; m_phase = 2; end
                2: begin m_bw = 0; m_phase = 3; end
                3: begin m_div = m_lat; m_phase = 4; end
                4: begin m_pwrdn = 0; m_phase = 5; m_wait = 0; end
                5: if (pll_lock) begin m_done = 1; m_phase = 0; end
                   else if (m_wait == T - 1) begin m_err = 1; m_phase = 0; end
                   else m_wait++;
                10: begin m_pwrdn = 1; m_phase = 11; end
                11: begin m_rst_n = 0; m_done = 1; m_phase = 0; end
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2", "pll_rst_n", int'(o_rst_n), m_rst_n);
            chk("R2", "pll_pwrdn", int'(o_pwrdn), m_pwrdn);
            chk("R3", "pll_bw", int'(o_bw), m_bw);
            chk("R4", "pll_div", int'(o_div), m_div);
            chk("R4", "fb_mult", int'(o_mult), m_div + 16);
            chk("R9", "busy", int'(o_busy), int'(m_phase != 0));
            chk("R5", "done", int'(o_done), m_done);
            chk("R6", "err", int'(o_err), m_err);
            chk("R8", "enabled", int'(o_en), int'(m_pwrdn == 0));
        end
    end

    task automatic req(input bit e, input bit d, input logic [2:0] dv);
        en_req = e; dis_req = d; div_cfg = dv;
        @(negedge clk);
        en_req = 0; dis_req = 0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_err);
        got_done = 0; got_err = 0;
        for (int i = 0; i < 200; i++) begin
            if (o_done || o_err) begin
                got_done = o_done; got_err = o_err;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit d, e;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "pll_rst_n", int'(o_rst_n), 0);
        chk("R1", "pll_pwrdn", int'(o_pwrdn), 1);
        chk("R1", "pll_bw", int'(o_bw), 3);
        chk("R1", "pll_div", int'(o_div), 0);
        chk("R1", "busy", int'(o_busy), 0);
        chk("R1", "done/err", int'(o_done) + int'(o_err), 0);
        chk("R1", "enabled", int'(o_en), 0);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;

        // plain bring-up, R2 step timing
        lock_dly = 3;
        req(1, 0, 3'd5);
        chk("R2", "rst released too early", int'(o_rst_n), 0);
        @(negedge clk);
        chk("R2", "rst released at E1", int'(o_rst_n), 1);
        chk("R3", "bw still reset code", int'(o_bw), 3);
        @(negedge clk);
        chk("R3", "bw good code at E2", int'(o_bw), 0);
        wait_end(d, e);
        chk("R5", "done after lock", int'(d), 1);
        chk("R4", "fb_mult 5+16", int'(o_mult), 21);
        chk("R8", "enabled after bring-up", int'(o_en), 1);

        // R9 requests during busy are ignored
        lock_dly = 4;
        req(1, 0, 3'd2);
        @(negedge clk);
        req(1, 0, 3'd7);
        req(0, 1, 3'd7);
        wait_end(d, e);
        chk("R9", "second run done", int'(d), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", "no extra sequence", int'(o_busy), 0);
        end
        chk("R9", "div from accepted request", int'(o_div), 2);

        // R7 tear-down order
        req(0, 1, 3'd0);
        chk("R7", "power still on at N1", int'(o_pwrdn), 0);
        @(negedge clk);
        chk("R7", "powered down at E1", int'(o_pwrdn), 1);
        chk("R7", "reset not yet applied", int'(o_rst_n), 1);
        @(negedge clk);
        chk("R7", "reset applied at E2", int'(o_rst_n), 0);
        chk("R7", "done after tear-down", int'(o_done), 1);

        // R6 timeout
        lock_dly = 1000;
        req(1, 0, 3'd0);
        wait_end(d, e);
        chk("R6", "timeout error", int'(e), 1);
        chk("R6", "left powered", int'(o_en), 1);
        chk("R4", "fb_mult 0+16", int'(o_mult), 16);
        req(0, 1, 3'd0);
        wait_end(d, e);

        // R5 lock in the last allowed wait cycle
        lock_dly = T;
        repeat (2) @(negedge clk);
        req(1, 0, 3'd7);
        wait_end(d, e);
        chk("R5", "lock at boundary is done", int'(d), 1);
        chk("R4", "fb_mult 7+16", int'(o_mult), 23);
        req(0, 1, 3'd0);
        wait_end(d, e);

        // R6 lock one cycle too late
        lock_dly = T + 1;
        repeat (2) @(negedge clk);
        req(1, 0, 3'd1);
        wait_end(d, e);
        chk("R6", "late lock is error", int'(e), 1);
        req(0, 1, 3'd0);
        wait_end(d, e);

        // R10 simultaneous requests
        lock_dly = 2;
        repeat (2) @(negedge clk);
        req(1, 0, 3'd4);
        wait_end(d, e);
        @(negedge clk);
        req(1, 1, 3'd3);
        wait_end(d, e);
        chk("R10", "disable wins", int'(o_en), 0);
        chk("R10", "reset applied", int'(o_rst_n), 0);
        chk("R10", "div unchanged", int'(o_div), 4);

        // second build: R11 R12 R8 (active-low power-down)
        chk("R12", "rst tied high", int'(b_rst_n), 1);
        chk("R8", "low polarity off", int'(b_en), 0);
        en2 = 1;
        @(negedge clk);
        en2 = 0;
        chk("R12", "busy in bw step", int'(b_busy), 1);
        @(negedge clk);
        chk("R12", "bw written first", int'(b_bw), 0);
        @(negedge clk);
        chk("R11", "not yet powered", int'(b_pwrdn), 0);
        @(negedge clk);
        chk("R11", "done with power-up", int'(b_done), 1);
        chk("R11", "busy low", int'(b_busy), 0);
        chk("R8", "low polarity on", int'(b_en), 1);
        chk("R4", "fb_mult 6+16", int'(b_mult), 22);
        dis2 = 1;
        @(negedge clk);
        dis2 = 0;
        @(negedge clk);
        chk("R12", "done after power-down", int'(b_done), 1);
        chk("R12", "rst still high", int'(b_rst_n), 1);
        chk("R8", "off again", int'(b_en), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule